// File: doc/BRIEF.md
# Debounced Wake-Input SMI Generator

This block watches a small set of asynchronous wake pins and turns qualified level changes into a System Management Interrupt request. Each pin passes through a two-flop synchronizer. It is then inverted or not by its own polarity bit and filtered by a per-pin debounce counter that advances on a slow tick input. The tick is meant to run at about 32.768 kHz, so one tick is roughly 31 µs. A change is accepted only after the new level has held through a set number of ticks. A transition of the filtered signal into its active state is an event. An event counts only when the pin is configured as an input and its SMI enable is set. When it counts, it sets one shared sticky status bit, and the SMI output follows that bit until software writes 1 to clear it.

The block also produces a System Control Interrupt. The SCI merges an already-selected GPIO event line and a power-up request line from peripheral wake sources, and each of the two is gated by its own global enable bit.

All configuration lives in four 8-bit registers on a simple write-strobe / combinational-read interface. Every register resets to zero.

Top module: `wake_smi_gen`

## Requirements
- R1: After reset all four registers read 00h, `smi_o` is 0 and `sci_o` is 0.
- R2: Register layout. Address 0: bit 0 enables GPIO SCI, bit 1 enables power-up SCI, bit 7 is the shared SMI status. Address 1 holds the per-pin polarity bits. Address 2 holds the per-pin SMI enables. Address 3 holds the per-pin direction bits. In addresses 1 to 3, pin i sits at bit i. Bits above the pin count read 0.
- R3: With polarity bit 0 a pin is active high. With polarity bit 1 it is active low, so a high-to-low pin change is the event.
- R4: A new polarity-corrected level is accepted only after it has stayed unchanged through DEB_TICKS tick pulses. A pulse shorter than that, or a level held without any tick, produces no event.
- R5: The return to the inactive level is also debounced. A brief drop and return does not make a new event, but a debounced release followed by a new debounced assertion does.
- R6: A pin whose direction bit is 1 (output) never sets the status.
- R7: A pin whose SMI enable bit is 0 never sets the status.
- R8: The status bit is sticky and `smi_o` equals it. Writing 1 to address 0 bit 7 clears it. Writing 0 there leaves it set. A pin held at its active level does not set it again after a clear.
- R9: Events from any pin set the same single status bit.
- R10: `sci_o` = (GPIO enable AND `gpio_evt_i`) OR (power-up enable AND `pwrup_req_i`), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle debounce tick, about 32.768 kHz |
| wake_pin_i | input | NPIN | Asynchronous wake pins |
| gpio_evt_i | input | 1 | Combined event from already-selected GPIO lines |
| pwrup_req_i | input | 1 | Power-up request from peripheral wake sources |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| smi_o | output | 1 | SMI request, equal to the sticky status |
| sci_o | output | 1 | SCI request |

## Verification
The hardest case to reach is a pin that changed level but was never accepted. This can be a glitch that returns before the tick arrives, or a short release of a held pin, and from the ports it looks the same as no activity at all. The bench drives the tick itself, so it can hold the pin changed for many clock cycles with no tick, put it back, and only then pulse the tick. It then looks at `smi_o` and the status read-back. A later fully debounced release and re-assertion shows that the filtered level really stayed active during the short drop.

// File: rtl/wake_smi_pkg.sv
package wake_smi_pkg;
   localparam int REG_W  = 8;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      ADR_CTL   = 2'd0,
      ADR_POL   = 2'd1,
      ADR_SMIEN = 2'd2,
      ADR_DIR   = 2'd3
   } wake_addr_e;

   localparam int BIT_GPIO_EN = 0;
   localparam int BIT_PWR_EN  = 1;
   localparam int BIT_STATUS  = 7;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad
      $error("wake_sync needs at least two stages");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[s] <= '0;
         else if (s == 0)
            stage_q[s] <= d_i;
         else
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce #(
   parameter int DEB_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic raw_i,
   output logic level_o,
   output logic rise_o
);
   localparam int CNT_W = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_TICKS - 1);

   if (DEB_TICKS < 1) begin : g_bad
      $error("DEB_TICKS must be at least 1");
   end

   logic             cand_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q  <= 1'b0;
         cnt_q   <= '0;
         level_o <= 1'b0;
         rise_o  <= 1'b0;
      end else begin
         rise_o <= 1'b0;
         if (raw_i != cand_q) begin
            cand_q <= raw_i;
            cnt_q  <= '0;
         end else if (tick_i && (cand_q != level_o)) begin
            if (cnt_q == LAST) begin
               level_o <= cand_q;
               rise_o  <= cand_q;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
   import wake_smi_pkg::*;
#(
   parameter int NPIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   input  logic [NPIN-1:0]   evt_i,
   output logic [NPIN-1:0]   pol_o,
   output logic [NPIN-1:0]   smi_en_o,
   output logic [NPIN-1:0]   dir_o,
   output logic              gpio_en_o,
   output logic              pwr_en_o,
   output logic              status_o
);
   logic clr_req;
   assign clr_req = wr_i && (addr_i == ADR_CTL) && wdata_i[BIT_STATUS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_o     <= '0;
         smi_en_o  <= '0;
         dir_o     <= '0;
         gpio_en_o <= 1'b0;
         pwr_en_o  <= 1'b0;
      end else if (wr_i) begin
         unique case (addr_i)
            ADR_CTL: begin
               gpio_en_o <= wdata_i[BIT_GPIO_EN];
               pwr_en_o  <= wdata_i[BIT_PWR_EN];
            end
            ADR_POL:   pol_o    <= wdata_i[NPIN-1:0];
            ADR_SMIEN: smi_en_o <= wdata_i[NPIN-1:0];
            ADR_DIR:   dir_o    <= wdata_i[NPIN-1:0];
            default: ;
         endcase
      end
   end

   // a new event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_o <= 1'b0;
      else if (|evt_i)
         status_o <= 1'b1;
      else if (clr_req)
         status_o <= 1'b0;
   end

   always_comb begin
      rdata_o = '0;
      unique case (addr_i)
         ADR_CTL: begin
            rdata_o[BIT_GPIO_EN] = gpio_en_o;
            rdata_o[BIT_PWR_EN]  = pwr_en_o;
            rdata_o[BIT_STATUS]  = status_o;
         end
         ADR_POL:   rdata_o[NPIN-1:0] = pol_o;
         ADR_SMIEN: rdata_o[NPIN-1:0] = smi_en_o;
         ADR_DIR:   rdata_o[NPIN-1:0] = dir_o;
         default: ;
      endcase
   end
endmodule

// File: rtl/wake_smi_gen.sv
module wake_smi_gen
   import wake_smi_pkg::*;
#(
   parameter int NPIN        = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_TICKS   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [NPIN-1:0]   wake_pin_i,
   input  logic              gpio_evt_i,
   input  logic              pwrup_req_i,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   output logic              smi_o,
   output logic              sci_o
);
   if (NPIN < 1 || NPIN > REG_W) begin : g_bad_npin
      $error("NPIN must lie in 1..REG_W");
   end

   logic [NPIN-1:0] pin_sync, pin_corr, deb_lvl, deb_rise, evt;
   logic [NPIN-1:0] pol_q, smi_en, dir_q;
   logic            gpio_en, pwr_en, status;

   wake_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(wake_pin_i), .q_o(pin_sync)
   );

   assign pin_corr = pin_sync ^ pol_q;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      wake_debounce #(.DEB_TICKS(DEB_TICKS)) deb_i (
         .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .raw_i(pin_corr[p]),
         .level_o(deb_lvl[p]), .rise_o(deb_rise[p])
      );
      assign evt[p] = deb_rise[p] & smi_en[p] & ~dir_q[p];
   end

   wake_regs #(.NPIN(NPIN)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .evt_i(evt),
      .pol_o(pol_q), .smi_en_o(smi_en), .dir_o(dir_q),
      .gpio_en_o(gpio_en), .pwr_en_o(pwr_en), .status_o(status)
   );

   assign smi_o = status;
   assign sci_o = (gpio_en & gpio_evt_i) | (pwr_en & pwrup_req_i);
endmodule

// File: rtl/wake_smi_chk.sv
module wake_smi_chk
   import wake_smi_pkg::*;
#(
   parameter int NPIN = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              reg_wr_i,
   input logic [ADDR_W-1:0] reg_addr_i,
   input logic [REG_W-1:0]  reg_wdata_i,
   input logic              smi_o,
   input logic              sci_o,
   input logic [NPIN-1:0]   evt,
   input logic [NPIN-1:0]   smi_en,
   input logic [NPIN-1:0]   dir_q,
   input logic [NPIN-1:0]   deb_lvl,
   input logic              gpio_en,
   input logic              pwr_en
);
   logic clr_wr;
   assign clr_wr = reg_wr_i && (reg_addr_i == ADR_CTL) && reg_wdata_i[BIT_STATUS];

   AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (deb_lvl != $past(deb_lvl)) |-> $past(tick_i)); // R4
   AST_SMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_o && !clr_wr) |=> smi_o); // R8
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && (evt == '0)) |=> !smi_o); // R8
   AST_ANY_PIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> smi_o); // R9
   AST_NO_QUALIFIED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_o && ((smi_en & ~dir_q) == '0)) |=> !smi_o); // R7
   AST_SCI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!gpio_en && !pwr_en) |-> !sci_o); // R10
endmodule

bind wake_smi_gen wake_smi_chk #(.NPIN(NPIN)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_wr_i(reg_wr_i),
   .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .smi_o(smi_o),
   .sci_o(sci_o), .evt(evt), .smi_en(smi_en), .dir_q(dir_q),
   .deb_lvl(deb_lvl), .gpio_en(gpio_en), .pwr_en(pwr_en)
);

// File: tb/wake_smi_gen_tb.sv
`timescale 1ns/1ps
module wake_smi_gen_tb_top;
   localparam int NPIN = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [2:0] wake_pin_i = '0;
   logic       gpio_evt_i = 1'b0;
   logic       pwrup_req_i = 1'b0;
   logic       reg_wr_i = 1'b0;
   logic [1:0] reg_addr_i = '0;
   logic [7:0] reg_wdata_i = '0;
   logic [7:0] reg_rdata_o;
   logic       smi_o, sci_o;

   always #4 clk = ~clk;

   wake_smi_gen #(.NPIN(NPIN)) dut_i (.*);

   typedef struct {
      logic       smi;
      logic       sci;
      logic [7:0] rd;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   total = 0;
   int   bad = 0;
   bit   finished = 0;

   // monitor: pops each expectation and compares with the outputs
   initial begin
      forever begin
         wait (exp_q.size() > 0);
         #1;
         begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (smi_o !== e.smi || sci_o !== e.sci || reg_rdata_o !== e.rd) begin
               bad++;
               $display("FAIL %s: got smi=%b sci=%b rd=%02h, expected smi=%b sci=%b rd=%02h",
                        e.tag, smi_o, sci_o, reg_rdata_o, e.smi, e.sci, e.rd);
            end
         end
      end
   end

   task automatic expect_state(input logic [1:0] a, input logic s, input logic c,
                               input logic [7:0] rd, input string tag);
      reg_addr_i = a;
      #1;
      exp_q.push_back('{smi: s, sci: c, rd: rd, tag: tag});
      wait (exp_q.size() == 0);
      #1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0; reg_wdata_i = '0;
   endtask

   task automatic set_pins(input logic [2:0] v);
      @(negedge clk);
      wake_pin_i = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++)
         expect_state(2'(a), 0, 0, 8'h00, "R1 reset");

      // R2 layout and unused bits
      wr(2'd1, 8'hFF); expect_state(2'd1, 0, 0, 8'h07, "R2 polarity reg");
      wr(2'd2, 8'hA5); expect_state(2'd2, 0, 0, 8'h05, "R2 enable reg");
      wr(2'd3, 8'h5A); expect_state(2'd3, 0, 0, 8'h02, "R2 direction reg");
      wr(2'd0, 8'h7F); expect_state(2'd0, 0, 0, 8'h03, "R2 control reg");
      wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h00);

      // R10 SCI gating
      gpio_evt_i = 1; pwrup_req_i = 1;
      expect_state(2'd0, 0, 0, 8'h00, "R10 both disabled");
      wr(2'd0, 8'h01); pwrup_req_i = 0;
      expect_state(2'd0, 0, 1, 8'h01, "R10 gpio path");
      gpio_evt_i = 0;
      expect_state(2'd0, 0, 0, 8'h01, "R10 gpio idle");
      wr(2'd0, 8'h02); pwrup_req_i = 1; gpio_evt_i = 1;
      expect_state(2'd0, 0, 1, 8'h02, "R10 power-up path");
      wr(2'd0, 8'h00); gpio_evt_i = 0; pwrup_req_i = 0;

      // R4 debounce on pin 0
      wr(2'd2, 8'h07);
      set_pins(3'b001); set_pins(3'b000); tick();
      expect_state(2'd0, 0, 0, 8'h00, "R4 glitch before tick");
      set_pins(3'b001); repeat (20) @(negedge clk);
      expect_state(2'd0, 0, 0, 8'h00, "R4 held without tick");
      tick();
      expect_state(2'd0, 1, 0, 8'h80, "R4 accepted after tick");

      // R8 sticky status
      wr(2'd0, 8'h00);
      expect_state(2'd0, 1, 0, 8'h80, "R8 write 0 keeps status");
      wr(2'd0, 8'h80);
      expect_state(2'd0, 0, 0, 8'h00, "R8 write 1 clears");
      tick(); tick();
      expect_state(2'd0, 0, 0, 8'h00, "R8 steady level no re-set");

      // R5 release debounced
      set_pins(3'b000); repeat (10) @(negedge clk); set_pins(3'b001); tick();
      expect_state(2'd0, 0, 0, 8'h00, "R5 short drop ignored");
      set_pins(3'b000); tick(); set_pins(3'b001); tick();
      expect_state(2'd0, 1, 0, 8'h80, "R5 release then assert");
      wr(2'd0, 8'h80); set_pins(3'b000); tick();

      // R9 another pin shares the status
      set_pins(3'b100); tick();
      expect_state(2'd0, 1, 0, 8'h80, "R9 pin 2 sets shared status");
      wr(2'd0, 8'h80); set_pins(3'b000); tick();

      // R6 output pin ignored
      wr(2'd3, 8'h02); set_pins(3'b010); tick();
      expect_state(2'd0, 0, 0, 8'h00, "R6 output pin no event");
      set_pins(3'b000); tick(); wr(2'd3, 8'h00);

      // R7 disabled pin ignored
      wr(2'd2, 8'h05); set_pins(3'b010); tick();
      expect_state(2'd0, 0, 0, 8'h00, "R7 disabled pin no event");
      set_pins(3'b000); tick();

      // R3 active-low polarity on pin 1 (enable off while setting up)
      wr(2'd2, 8'h00);
      set_pins(3'b010); tick();
      wr(2'd1, 8'h02); repeat (4) @(negedge clk); tick();
      wr(2'd2, 8'h02);
      expect_state(2'd0, 0, 0, 8'h00, "R3 idle high inactive");
      set_pins(3'b000); tick();
      expect_state(2'd0, 1, 0, 8'h80, "R3 falling edge is event");
      wr(2'd0, 8'h80);
      expect_state(2'd0, 0, 0, 8'h00, "R3 cleared");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule